// File: doc/BRIEF.md
# Tagged Associative Translation Buffer

This block caches page mappings. It turns a virtual address into a physical address, with a result one cycle after each lookup. It holds a parameterized number of entries, 64 by default, and compares all of them in parallel. An entry matches when its page number equals the upper bits of the virtual address and its process tag equals the current process identifier. When nothing matches, the block raises a miss trap and does not walk any table. Software services the trap and installs the missing mapping through the fill port.

Each entry also carries dirty, referenced, writable and valid bits. A write to a page that is not writable raises a protection fault instead of a translation. A hit updates the referenced bit, and a write hit also updates the dirty bit. A one-cycle invalidate input drops every mapping at a context switch. Fills choose their slot in a fixed order: an existing copy of the same mapping first, then a free slot, then a round-robin victim.

With the default sizes, the virtual address is 24 bits: bits 12..0 are the page offset and bits 23..13 are the page number. The physical address is 32 bits: the frame number from the entry goes in bits 31..13, and the offset passes through unchanged.

Top module: `xbuf_top`

## Requirements
- R1: After reset every entry is invalid and rs_valid, rs_hit, rs_miss, rs_fault, rs_dirty, rs_ref and rs_paddr are all 0. A lookup made right after reset misses.
- R2: A lookup of kind read (lk_kind 00) or execute (lk_kind 10) finds a valid entry when both the page number lk_vaddr[23:13] and cur_pid match that entry. One cycle later it gives rs_valid=1 and rs_hit=1, with rs_paddr = {frame number, lk_vaddr[12:0]}.
- R3: An entry whose process tag differs from cur_pid never hits, even when its page number matches. Such a lookup reports a miss.
- R4: Every lookup gives exactly one of rs_hit, rs_miss or rs_fault together with rs_valid=1 in the next cycle. No lookup gives rs_valid=0 in the next cycle. A miss or a fault drives rs_paddr to 0.
- R5: A write (lk_kind 01) that finds an entry whose writable bit is clear gives rs_fault=1 and rs_paddr=0. It changes neither the dirty bit nor the referenced bit of that entry. A write that finds a writable entry hits.
- R6: Every hit sets the entry's referenced bit, and a write hit also sets its dirty bit. On a hit, rs_ref and rs_dirty show the values these bits held before that access.
- R7: A fill that matches a valid entry on the same page number and process tag rewrites that entry in place. Otherwise the fill takes the lowest-numbered invalid slot. When all slots are valid, it takes the slot named by a round-robin pointer. The pointer starts at 0 after reset and advances by one, wrapping, only on fills that use it. A filled entry starts with dirty=0 and referenced=0.
- R8: A one-cycle ctx_inval makes every entry invalid from the next cycle on. A fill in the same cycle is still installed and valid afterwards.
- R9: A lookup in the same cycle as a fill or an invalidate sees the buffer contents from before that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_valid | input | 1 | Lookup request this cycle |
| lk_vaddr | input | 24 | Virtual address to translate |
| lk_kind | input | 2 | Access kind: 00 read, 01 write, 10 execute |
| cur_pid | input | 8 | Current process identifier |
| fl_en | input | 1 | Install an entry this cycle |
| fl_vpn | input | 11 | Page number of the new entry |
| fl_pfn | input | 19 | Frame number of the new entry |
| fl_pid | input | 8 | Process tag of the new entry |
| fl_writable | input | 1 | Writable bit of the new entry |
| ctx_inval | input | 1 | Clear every valid bit |
| rs_valid | output | 1 | Result present (one cycle after lookup) |
| rs_hit | output | 1 | Translation succeeded |
| rs_miss | output | 1 | Miss trap: no matching valid entry |
| rs_fault | output | 1 | Protection fault on write |
| rs_paddr | output | 32 | Physical address, 0 unless hit |
| rs_dirty | output | 1 | Dirty bit of the hit entry before the access |
| rs_ref | output | 1 | Referenced bit of the hit entry before the access |

## Verification
A lookup can fall in the same cycle as a fill or a context-switch invalidate. The bench provokes this by driving both requests in one cycle. One case rewrites a mapping that is being looked up. Another installs a page that is missing at that moment. A third invalidates while a hit is in flight. Each lookup must report the old contents. The follow-up lookups must show the new frame, the newly installed page and the cleared buffer, and a fill made during the invalidate must survive it.

// File: rtl/xbuf_pkg.sv
package xbuf_pkg;
  localparam logic [1:0] KIND_READ  = 2'b00;
  localparam logic [1:0] KIND_WRITE = 2'b01;
  localparam logic [1:0] KIND_EXEC  = 2'b10;

  function automatic int idx_bits(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/xbuf_match.sv
module xbuf_match #(
  parameter int N     = 64,
  parameter int VPN_W = 11,
  parameter int PID_W = 8,
  localparam int IDX_W = xbuf_pkg::idx_bits(N)
) (
  input  logic [N-1:0]            ent_vld,
  input  logic [N-1:0][VPN_W-1:0] ent_vpn,
  input  logic [N-1:0][PID_W-1:0] ent_pid,
  input  logic [VPN_W-1:0]        key_vpn,
  input  logic [PID_W-1:0]        key_pid,
  output logic                    hit_any,
  output logic [IDX_W-1:0]        hit_idx
);
  logic [N-1:0] hit_vec;

  // one comparator per entry, all evaluated in parallel
  for (genvar g = 0; g < N; g++) begin : g_cmp
    assign hit_vec[g] = ent_vld[g] && (ent_vpn[g] == key_vpn) && (ent_pid[g] == key_pid);
  end

  assign hit_any = |hit_vec;

  // lowest index wins should duplicates ever exist
  always_comb begin
    hit_idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (hit_vec[i]) hit_idx = IDX_W'(i);
    end
  end
endmodule

// File: rtl/xbuf_victim.sv
module xbuf_victim #(
  parameter int N = 64,
  localparam int IDX_W = xbuf_pkg::idx_bits(N)
) (
  input  logic [N-1:0]     ent_vld,
  input  logic             same_hit,
  input  logic [IDX_W-1:0] same_idx,
  input  logic [IDX_W-1:0] rr_ptr,
  output logic [IDX_W-1:0] slot,
  output logic             take_rr
);
  logic             free_any;
  logic [IDX_W-1:0] free_idx;

  assign free_any = ~&ent_vld;

  always_comb begin
    free_idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (!ent_vld[i]) free_idx = IDX_W'(i);
    end
  end

  always_comb begin
    take_rr = 1'b0;
    if (same_hit) begin
      slot = same_idx;
    end else if (free_any) begin
      slot = free_idx;
    end else begin
      slot    = rr_ptr;
      take_rr = 1'b1;
    end
  end
endmodule

// File: rtl/xbuf_frame_ram.sv
module xbuf_frame_ram #(
  parameter int DEPTH = 64,
  parameter int W     = 19,
  localparam int AW   = xbuf_pkg::idx_bits(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  logic [W-1:0] mem [DEPTH];

  // simple dual port, read returns the old word on a same-address write
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/xbuf_top.sv
module xbuf_top #(
  parameter int ENTRIES = 64,
  parameter int VA_W    = 24,
  parameter int PA_W    = 32,
  parameter int OFF_W   = 13,
  parameter int PID_W   = 8,
  localparam int VPN_W  = VA_W - OFF_W,
  localparam int PFN_W  = PA_W - OFF_W,
  localparam int IDX_W  = xbuf_pkg::idx_bits(ENTRIES)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             lk_valid,
  input  logic [VA_W-1:0]  lk_vaddr,
  input  logic [1:0]       lk_kind,
  input  logic [PID_W-1:0] cur_pid,
  input  logic             fl_en,
  input  logic [VPN_W-1:0] fl_vpn,
  input  logic [PFN_W-1:0] fl_pfn,
  input  logic [PID_W-1:0] fl_pid,
  input  logic             fl_writable,
  input  logic             ctx_inval,
  output logic             rs_valid,
  output logic             rs_hit,
  output logic             rs_miss,
  output logic             rs_fault,
  output logic [PA_W-1:0]  rs_paddr,
  output logic             rs_dirty,
  output logic             rs_ref
);
  // entry state held in flops for the parallel compare
  logic [ENTRIES-1:0]            vld_q;
  logic [ENTRIES-1:0]            wr_q;
  logic [ENTRIES-1:0]            dirty_q;
  logic [ENTRIES-1:0]            ref_q;
  logic [ENTRIES-1:0][VPN_W-1:0] vpn_q;
  logic [ENTRIES-1:0][PID_W-1:0] pid_q;
  logic [IDX_W-1:0]              rr_q;

  // lookup side
  logic [VPN_W-1:0] lk_vpn;
  logic             lk_any;
  logic [IDX_W-1:0] lk_idx;
  logic             lk_is_wr;
  logic             lk_deny;
  logic             lk_ok;

  // fill side
  logic             fl_same;
  logic [IDX_W-1:0] fl_same_idx;
  logic [IDX_W-1:0] fl_slot;
  logic             fl_take_rr;

  // result registers
  logic [OFF_W-1:0] off_q;
  logic [PFN_W-1:0] frame_rd;

  assign lk_vpn   = lk_vaddr[VA_W-1:OFF_W];
  assign lk_is_wr = (lk_kind == xbuf_pkg::KIND_WRITE);

  xbuf_match #(.N(ENTRIES), .VPN_W(VPN_W), .PID_W(PID_W)) u_lk_match (
    .ent_vld (vld_q),
    .ent_vpn (vpn_q),
    .ent_pid (pid_q),
    .key_vpn (lk_vpn),
    .key_pid (cur_pid),
    .hit_any (lk_any),
    .hit_idx (lk_idx)
  );

  xbuf_match #(.N(ENTRIES), .VPN_W(VPN_W), .PID_W(PID_W)) u_fl_match (
    .ent_vld (vld_q),
    .ent_vpn (vpn_q),
    .ent_pid (pid_q),
    .key_vpn (fl_vpn),
    .key_pid (fl_pid),
    .hit_any (fl_same),
    .hit_idx (fl_same_idx)
  );

  xbuf_victim #(.N(ENTRIES)) u_victim (
    .ent_vld  (vld_q),
    .same_hit (fl_same),
    .same_idx (fl_same_idx),
    .rr_ptr   (rr_q),
    .slot     (fl_slot),
    .take_rr  (fl_take_rr)
  );

  xbuf_frame_ram #(.DEPTH(ENTRIES), .W(PFN_W)) u_frames (
    .clk   (clk),
    .we    (fl_en),
    .waddr (fl_slot),
    .wdata (fl_pfn),
    .re    (lk_valid && lk_any),
    .raddr (lk_idx),
    .rdata (frame_rd)
  );

  assign lk_deny = lk_any && lk_is_wr && !wr_q[lk_idx];
  assign lk_ok   = lk_valid && lk_any && !lk_deny;

  // entry state: flag update, then invalidate, then fill (last write wins)
  always_ff @(posedge clk) begin
    if (rst) begin
      vld_q   <= '0;
      wr_q    <= '0;
      dirty_q <= '0;
      ref_q   <= '0;
      vpn_q   <= '0;
      pid_q   <= '0;
      rr_q    <= '0;
    end else begin
      if (lk_ok) begin
        ref_q[lk_idx] <= 1'b1;
        if (lk_is_wr) dirty_q[lk_idx] <= 1'b1;
      end
      if (ctx_inval) vld_q <= '0;
      if (fl_en) begin
        vpn_q[fl_slot]   <= fl_vpn;
        pid_q[fl_slot]   <= fl_pid;
        wr_q[fl_slot]    <= fl_writable;
        vld_q[fl_slot]   <= 1'b1;
        dirty_q[fl_slot] <= 1'b0;
        ref_q[fl_slot]   <= 1'b0;
        if (fl_take_rr) begin
          rr_q <= (rr_q == IDX_W'(ENTRIES - 1)) ? '0 : rr_q + 1'b1;
        end
      end
    end
  end

  // registered result, computed from the pre-edge contents
  always_ff @(posedge clk) begin
    if (rst) begin
      rs_valid <= 1'b0;
      rs_hit   <= 1'b0;
      rs_miss  <= 1'b0;
      rs_fault <= 1'b0;
      rs_dirty <= 1'b0;
      rs_ref   <= 1'b0;
      off_q    <= '0;
    end else begin
      rs_valid <= lk_valid;
      rs_hit   <= lk_ok;
      rs_miss  <= lk_valid && !lk_any;
      rs_fault <= lk_valid && lk_deny;
      rs_dirty <= lk_ok && dirty_q[lk_idx];
      rs_ref   <= lk_ok && ref_q[lk_idx];
      off_q    <= lk_vaddr[OFF_W-1:0];
    end
  end

  assign rs_paddr = rs_hit ? {frame_rd, off_q} : '0;
endmodule

// File: rtl/xbuf_chk.sv
module xbuf_chk #(
  parameter int ENTRIES = 64,
  parameter int VA_W    = 24,
  parameter int PA_W    = 32,
  parameter int OFF_W   = 13
) (
  input logic               clk,
  input logic               rst,
  input logic               lk_valid,
  input logic [VA_W-1:0]    lk_vaddr,
  input logic               fl_en,
  input logic               ctx_inval,
  input logic               rs_valid,
  input logic               rs_hit,
  input logic               rs_miss,
  input logic               rs_fault,
  input logic [PA_W-1:0]    rs_paddr,
  input logic [ENTRIES-1:0] vld_q
);
  a_r4_result_follows: assert property (@(posedge clk) disable iff (rst)
    lk_valid |=> rs_valid);

  a_r4_no_spurious: assert property (@(posedge clk) disable iff (rst)
    !lk_valid |=> !rs_valid);

  a_r4_one_outcome: assert property (@(posedge clk) disable iff (rst)
    rs_valid |-> ($countones({rs_hit, rs_miss, rs_fault}) == 1));

  a_r4_miss_zero: assert property (@(posedge clk) disable iff (rst)
    rs_miss |-> (rs_paddr == '0));

  a_r5_fault_zero: assert property (@(posedge clk) disable iff (rst)
    rs_fault |-> (rs_paddr == '0));

  a_r2_offset_kept: assert property (@(posedge clk) disable iff (rst)
    lk_valid |=> (!rs_hit || (rs_paddr[OFF_W-1:0] == $past(lk_vaddr[OFF_W-1:0]))));

  a_r7_fill_lands: assert property (@(posedge clk) disable iff (rst)
    fl_en |=> (vld_q != '0));

  a_r8_inval_clears: assert property (@(posedge clk) disable iff (rst)
    (ctx_inval && !fl_en) |=> (vld_q == '0));

  a_r8_valid_only_drops_on_inval: assert property (@(posedge clk) disable iff (rst)
    !ctx_inval |=> ($countones(vld_q) >= $past($countones(vld_q))));
endmodule

bind xbuf_top xbuf_chk #(
  .ENTRIES (ENTRIES),
  .VA_W    (VA_W),
  .PA_W    (PA_W),
  .OFF_W   (OFF_W)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .lk_valid  (lk_valid),
  .lk_vaddr  (lk_vaddr),
  .fl_en     (fl_en),
  .ctx_inval (ctx_inval),
  .rs_valid  (rs_valid),
  .rs_hit    (rs_hit),
  .rs_miss   (rs_miss),
  .rs_fault  (rs_fault),
  .rs_paddr  (rs_paddr),
  .vld_q     (vld_q)
);

// File: tb/sim_xbuf_top.sv
module sim_xbuf_top;
  localparam int CLK_PERIOD = 10;
  localparam int N = 64;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        lk_valid = 1'b0;
  logic [23:0] lk_vaddr = '0;
  logic [1:0]  lk_kind = '0;
  logic [7:0]  cur_pid = '0;
  logic        fl_en = 1'b0;
  logic [10:0] fl_vpn = '0;
  logic [18:0] fl_pfn = '0;
  logic [7:0]  fl_pid = '0;
  logic        fl_writable = 1'b0;
  logic        ctx_inval = 1'b0;
  logic        rs_valid, rs_hit, rs_miss, rs_fault, rs_dirty, rs_ref;
  logic [31:0] rs_paddr;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  logic [5:0]  o_flags;
  logic [31:0] o_paddr;

  localparam logic [5:0] F_MISS  = 6'b101000;
  localparam logic [5:0] F_FAULT = 6'b100100;

  always #(CLK_PERIOD / 2) clk = ~clk;

  xbuf_top u0 (
    .clk(clk), .rst(rst), .lk_valid(lk_valid), .lk_vaddr(lk_vaddr), .lk_kind(lk_kind),
    .cur_pid(cur_pid), .fl_en(fl_en), .fl_vpn(fl_vpn), .fl_pfn(fl_pfn), .fl_pid(fl_pid),
    .fl_writable(fl_writable), .ctx_inval(ctx_inval), .rs_valid(rs_valid), .rs_hit(rs_hit),
    .rs_miss(rs_miss), .rs_fault(rs_fault), .rs_paddr(rs_paddr), .rs_dirty(rs_dirty),
    .rs_ref(rs_ref)
  );

  function automatic logic [10:0] vpn_of(input int i);
    return 11'((i * 29 + 5) % 2048);
  endfunction
  function automatic logic [18:0] pfn_of(input int i);
    return 19'((i * 37 + 1000) % 524288);
  endfunction
  function automatic logic [7:0] pid_of(input int i);
    return 8'(i % 4);
  endfunction
  function automatic logic [12:0] off_of(input int i);
    return 13'((i * 613 + 77) % 8192);
  endfunction
  function automatic logic [5:0] f_hit(input logic d, input logic r);
    return {4'b1100, d, r};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(input logic lv, input logic [10:0] vpn, input logic [12:0] off,
                      input logic [7:0] pid, input logic [1:0] kind,
                      input logic fe, input logic [10:0] fvpn, input logic [18:0] fpfn,
                      input logic [7:0] fpid, input logic fwr, input logic inv);
    @(negedge clk);
    lk_valid = lv; lk_vaddr = {vpn, off}; cur_pid = pid; lk_kind = kind;
    fl_en = fe; fl_vpn = fvpn; fl_pfn = fpfn; fl_pid = fpid; fl_writable = fwr;
    ctx_inval = inv;
    @(negedge clk);
    o_flags = {rs_valid, rs_hit, rs_miss, rs_fault, rs_dirty, rs_ref};
    o_paddr = rs_paddr;
    lk_valid = 1'b0; fl_en = 1'b0; ctx_inval = 1'b0;
  endtask

  task automatic lookup(input logic [10:0] vpn, input logic [12:0] off,
                        input logic [7:0] pid, input logic [1:0] kind);
    step(1'b1, vpn, off, pid, kind, 1'b0, '0, '0, '0, 1'b0, 1'b0);
  endtask

  task automatic fill(input logic [10:0] vpn, input logic [18:0] pfn,
                      input logic [7:0] pid, input logic wr);
    step(1'b0, '0, '0, '0, 2'b00, 1'b1, vpn, pfn, pid, wr, 1'b0);
  endtask

  task automatic expect_res(input string req, input logic [5:0] fl, input logic [31:0] pa);
    check({req, " flags"}, 32'(o_flags), 32'(fl));
    check({req, " paddr"}, o_paddr, pa);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    check("R1 outputs idle", {25'd0, rs_valid, rs_hit, rs_miss, rs_fault, rs_dirty, rs_ref, 1'b0}, 32'd0);
    check("R1 paddr idle", rs_paddr, 32'd0);
    lookup(vpn_of(0), off_of(0), pid_of(0), 2'b00);
    expect_res("R1 empty miss", F_MISS, 32'd0);

    for (int i = 0; i < N; i++) fill(vpn_of(i), pfn_of(i), pid_of(i), (i % 2) == 0);

    for (int i = 0; i < N; i++) begin
      lookup(vpn_of(i), off_of(i), pid_of(i), 2'b00);
      expect_res("R2 read hit", f_hit(1'b0, 1'b0), {pfn_of(i), off_of(i)});
      lookup(vpn_of(i), off_of(i), pid_of(i + 1), 2'b00);
      expect_res("R3 pid mismatch", F_MISS, 32'd0);
      lookup(vpn_of(i), off_of(i + 5), pid_of(i), 2'b10);
      expect_res("R6 exec hit ref", f_hit(1'b0, 1'b1), {pfn_of(i), off_of(i + 5)});
      lookup(vpn_of(i), off_of(i), pid_of(i), 2'b01);
      if (i % 2 == 0) expect_res("R6 write hit", f_hit(1'b0, 1'b1), {pfn_of(i), off_of(i)});
      else            expect_res("R5 write fault", F_FAULT, 32'd0);
      lookup(vpn_of(i), off_of(i), pid_of(i), 2'b00);
      expect_res("R5 R6 dirty after write", f_hit((i % 2) == 0, 1'b1), {pfn_of(i), off_of(i)});
    end

    // R7 round-robin eviction once full
    fill(11'd1861, 19'h11111, 8'd0, 1'b1);
    lookup(vpn_of(0), off_of(0), pid_of(0), 2'b00);
    expect_res("R7 slot0 evicted", F_MISS, 32'd0);
    lookup(11'd1861, 13'h0abc, 8'd0, 2'b00);
    expect_res("R7 new entry fresh", f_hit(1'b0, 1'b0), {19'h11111, 13'h0abc});
    fill(11'd1890, 19'h22222, 8'd0, 1'b1);
    lookup(vpn_of(1), off_of(1), pid_of(1), 2'b00);
    expect_res("R7 slot1 evicted", F_MISS, 32'd0);
    lookup(vpn_of(2), off_of(2), pid_of(2), 2'b00);
    expect_res("R7 slot2 kept", f_hit(1'b1, 1'b1), {pfn_of(2), off_of(2)});
    // R7 in-place rewrite does not move the pointer
    fill(vpn_of(5), 19'd12345, pid_of(5), 1'b1);
    lookup(vpn_of(5), 13'd9, pid_of(5), 2'b01);
    expect_res("R7 rewrite in place", f_hit(1'b0, 1'b0), {19'd12345, 13'd9});
    fill(11'd1919, 19'h33333, 8'd0, 1'b0);
    lookup(vpn_of(2), off_of(2), pid_of(2), 2'b00);
    expect_res("R7 slot2 evicted", F_MISS, 32'd0);
    lookup(vpn_of(3), off_of(3), pid_of(3), 2'b00);
    expect_res("R7 slot3 kept", f_hit(1'b0, 1'b1), {pfn_of(3), off_of(3)});

    // R9 lookup concurrent with a fill of the same mapping
    step(1'b1, vpn_of(3), 13'd1, pid_of(3), 2'b00, 1'b1, vpn_of(3), 19'd777, pid_of(3), 1'b1, 1'b0);
    expect_res("R9 old frame seen", f_hit(1'b0, 1'b1), {pfn_of(3), 13'd1});
    lookup(vpn_of(3), 13'd2, pid_of(3), 2'b00);
    expect_res("R9 new frame after", f_hit(1'b0, 1'b0), {19'd777, 13'd2});
    step(1'b1, 11'd1948, 13'd3, 8'd1, 2'b00, 1'b1, 11'd1948, 19'd4444, 8'd1, 1'b1, 1'b0);
    expect_res("R9 miss before fill", F_MISS, 32'd0);
    lookup(11'd1948, 13'd4, 8'd1, 2'b00);
    expect_res("R9 hit after fill", f_hit(1'b0, 1'b0), {19'd4444, 13'd4});

    // R8 invalidate with a concurrent lookup and fill
    step(1'b1, 11'd1948, 13'd5, 8'd1, 2'b00, 1'b1, 11'd1977, 19'd4242, 8'd2, 1'b1, 1'b1);
    expect_res("R9 hit during inval", f_hit(1'b0, 1'b1), {19'd4444, 13'd5});
    lookup(11'd1948, 13'd5, 8'd1, 2'b00);
    expect_res("R8 cleared", F_MISS, 32'd0);
    lookup(vpn_of(10), off_of(10), pid_of(10), 2'b00);
    expect_res("R8 cleared old", F_MISS, 32'd0);
    lookup(11'd1977, 13'd6, 8'd2, 2'b00);
    expect_res("R8 fill survives", f_hit(1'b0, 1'b0), {19'd4242, 13'd6});

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule